// File: doc/BRIEF.md
# Character cell pixel serializer

The block turns one pattern byte per character position into a run of pixels on a scan line. Each character cell is a programmable number of pixels wide. A separate field sets how many of the byte's pattern bits appear at the start of the cell. Cell positions past the active count are blank, which gives spacing between characters. A downstream counter can multiply cells by width using the `cell_start` strobe. The block does not count positions along the line.

An 8-bit control word holds both fields. The low nibble is the active pattern count. The high nibble is the cell width minus one. The block samples the control word only at a cell boundary. At that same boundary it raises `pat_ready` and takes the next pattern byte through a valid/ready handshake. When no byte is offered at that moment, the whole cell is blank. Pixels advance on cycles where the pixel enable is high. Lowering the line enable blanks the output and rewinds the cell to its first pixel.

Top module: `char_cell_serializer`

## Requirements
- R1: After reset, `pix_fg` and `cell_start` are 0 and the control word is 8'h78. This gives cells 8 pixels wide with all 8 pattern bits active.
- R2: A cell lasts (ctrl[7:4] + 1) enabled pixels. Field value 0 gives single-pixel cells, and `cell_start` then pulses on every enabled pixel.
- R3: Pattern bits leave bit 7 first, one bit per enabled pixel. A bit value of 1 gives `pix_fg` = 1.
- R4: When ctrl[3:0] is smaller than the cell width, pixel i of the cell shows pattern bit 7-i for i < ctrl[3:0], and the rest of the cell is blank.
- R5: When ctrl[3:0] is larger than the cell width, only the first width pattern bits are shown. The next cell starts on time.
- R6: An active field of 9 to 15 shows at most 8 pattern bits. Any further cell pixels are blank.
- R7: An active field of 0 makes every pixel of the cell blank.
- R8: `pat_ready` is high exactly on enabled cycles at a cell's first pixel, and `cell_start` is high in the following cycle. If `pat_valid` is low when `pat_ready` is high, the whole cell is blank.
- R9: A control write becomes active at the next cell boundary. A cell that is already running keeps its width and active count.
- R10: While `line_en` is low, `pix_fg`, `cell_start` and `pat_ready` are 0. The first enabled pixel after `line_en` rises begins a new cell.
- R11: On cycles with `pix_en` low, the cell does not advance, `pix_fg` keeps its value and `cell_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel clock enable, one pixel per high cycle |
| line_en | input | 1 | Active part of the scan line |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word: [7:4] width minus one, [3:0] active count |
| pat_valid | input | 1 | Pattern byte offered |
| pat_data | input | 8 | Pattern byte, bit 7 first |
| pat_ready | output | 1 | Pattern byte taken this cycle (cell boundary) |
| pix_fg | output | 1 | Pixel is foreground (1) or blank (0) |
| cell_start | output | 1 | Strobe: the pixel now on `pix_fg` is a cell's first pixel |

## Verification
The hardest case to reach is a control write that lands in the middle of a cell, while pixel enables are sparse and a pattern byte may be missing at the boundary. Only the combination shows whether the running cell keeps its old width while the next cell picks up the new one. The final stimulus phase covers it by writing random control words at random cycles. In the same phase, pixel enable, byte valid and line enable are all random. A behavioural model in the bench, based on queue-free integer counters, predicts every output on every clock.

// File: rtl/cell_ser_pkg.sv
// Package: shared control-word layout and the active-count clamp.
// Assumes the control word is two equal nibbles, width-minus-one on top.
package cell_ser_pkg;
    localparam int FIELD_W = 4;
    localparam int CTRL_W  = 2 * FIELD_W;

    typedef struct packed {
        logic [FIELD_W-1:0] width_m1;
        logic [FIELD_W-1:0] active;
    } cell_cfg_t;

    // Limit the active field to the number of bits in one pattern byte.
    function automatic logic [FIELD_W-1:0] clamp_active(
        input logic [FIELD_W-1:0] act, input int unsigned limit);
        return (act > limit[FIELD_W-1:0]) ? limit[FIELD_W-1:0] : act;
    endfunction
endpackage

// File: rtl/cell_ser_cfg.sv
// Module: holds the written control word and the copy used by the running
// cell. Assumes the load strobe is high only at a cell boundary.
module cell_ser_cfg
    import cell_ser_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_CTRL = 8'h78
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              load,
    output cell_cfg_t         pend_o,
    output cell_cfg_t         cur_o
);
    cell_cfg_t pend_q, cur_q;

    // Capture software writes at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)  pend_q <= cell_cfg_t'(RESET_CTRL);
        else if (wr) pend_q <= cell_cfg_t'(wdata);
    end

    // Move the written word into use only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur_q <= cell_cfg_t'(RESET_CTRL);
        else if (load) cur_q <= pend_q;
    end

    assign pend_o = pend_q;
    assign cur_o  = cur_q;
endmodule

// File: rtl/cell_ser_count.sv
// Module: pixel position inside the current cell. Position 0 is the
// boundary. Assumes width values are already width-minus-one.
module cell_ser_count
    import cell_ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               clr,
    input  logic [FIELD_W-1:0] width_cur,
    input  logic [FIELD_W-1:0] width_new,
    output logic [FIELD_W-1:0] pos_o,
    output logic               at_start_o
);
    logic [FIELD_W-1:0] pos_q;

    // Advance one position per enabled pixel and wrap at the cell width.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos_q <= '0;
        end else if (step) begin
            if (pos_q == '0)
                pos_q <= (width_new == '0) ? '0 : FIELD_W'(1);
            else if (pos_q == width_cur)
                pos_q <= '0;
            else
                pos_q <= pos_q + FIELD_W'(1);
        end
    end

    assign pos_o      = pos_q;
    assign at_start_o = (pos_q == '0);
endmodule

// File: rtl/cell_ser_shift.sv
// Module: pattern shift register and pixel decision. Assumes the load
// strobe is high only at a cell boundary and that pos counts from 0.
module cell_ser_shift
    import cell_ser_pkg::*;
#(
    parameter int PAT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               clr,
    input  logic               load,
    input  logic               valid,
    input  logic [PAT_W-1:0]   data,
    input  logic [FIELD_W-1:0] act_new,
    input  logic [FIELD_W-1:0] pos,
    output logic               pix_o
);
    logic [PAT_W-1:0]   sh_q;
    logic [FIELD_W-1:0] act_q;
    logic               have_q;
    logic               pix_q;
    logic [FIELD_W-1:0] act_lim;

    // Active count after the byte-width ceiling.
    always_comb act_lim = clamp_active(act_new, PAT_W);

    // Load a byte at the boundary, otherwise shift one bit per pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh_q   <= '0;
            act_q  <= '0;
            have_q <= 1'b0;
            pix_q  <= 1'b0;
        end else if (step) begin
            if (load) begin
                have_q <= valid;
                act_q  <= act_lim;
                sh_q   <= {data[PAT_W-2:0], 1'b0};
                pix_q  <= valid && (act_lim != '0) && data[PAT_W-1];
            end else begin
                sh_q   <= {sh_q[PAT_W-2:0], 1'b0};
                pix_q  <= have_q && (pos < act_q) && sh_q[PAT_W-1];
            end
        end
    end

    assign pix_o = pix_q;
endmodule

// File: rtl/char_cell_serializer.sv
// Module: top of the character cell serializer. Connects the control-word
// holder, the position counter and the shifter. Assumes the upstream
// source keeps pat_data stable while pat_valid is high.
module char_cell_serializer
    import cell_ser_pkg::*;
#(
    parameter int                PAT_W      = 8,
    parameter logic [CTRL_W-1:0] RESET_CTRL = 8'h78
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              line_en,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              pat_valid,
    input  logic [PAT_W-1:0]  pat_data,
    output logic              pat_ready,
    output logic              pix_fg,
    output logic              cell_start
);
    cell_cfg_t          cfg_pend, cfg_cur;
    logic [FIELD_W-1:0] pos;
    logic               at_start;
    logic               step;
    logic               boundary;
    logic               start_q;

    // One enabled pixel inside the active line.
    always_comb step     = pix_en && line_en;
    // The first pixel of a cell, which takes a byte and a control word.
    always_comb boundary = step && at_start;

    cell_ser_cfg #(.RESET_CTRL(RESET_CTRL)) i_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctrl_wr),
        .wdata  (ctrl_wdata),
        .load   (boundary),
        .pend_o (cfg_pend),
        .cur_o  (cfg_cur)
    );

    cell_ser_count i_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .clr        (!line_en),
        .width_cur  (cfg_cur.width_m1),
        .width_new  (cfg_pend.width_m1),
        .pos_o      (pos),
        .at_start_o (at_start)
    );

    cell_ser_shift #(.PAT_W(PAT_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .clr     (!line_en),
        .load    (boundary),
        .valid   (pat_valid),
        .data    (pat_data),
        .act_new (cfg_pend.active),
        .pos     (pos),
        .pix_o   (pix_fg)
    );

    // Strobe that lines up with the first pixel of each cell.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= boundary;
    end

    assign pat_ready  = boundary;
    assign cell_start = start_q;
endmodule

// File: rtl/cell_ser_checker.sv
// Module: protocol checks on the serializer's ports, attached by bind.
module cell_ser_checker (
    input logic clk,
    input logic rst_n,
    input logic pix_en,
    input logic line_en,
    input logic pat_valid,
    input logic pat_ready,
    input logic pix_fg,
    input logic cell_start
);
    // R10
    line_off_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |=> (!pix_fg && !cell_start));
    // R10
    line_off_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |-> !pat_ready);
    // R8
    ready_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_ready |-> (pix_en && line_en));
    // R8
    ready_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_ready |=> cell_start);
    // R8
    empty_cell_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_ready && !pat_valid) |=> !pix_fg);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && !pix_en) |=> (pix_fg == $past(pix_fg)));
    // R11
    idle_nostrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> !cell_start);
endmodule

bind char_cell_serializer cell_ser_checker i_cell_ser_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .line_en    (line_en),
    .pat_valid  (pat_valid),
    .pat_ready  (pat_ready),
    .pix_fg     (pix_fg),
    .cell_start (cell_start)
);

// File: tb/test_char_cell_serializer.sv
`timescale 1ns/1ps
module test_char_cell_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_en = 1'b0, line_en = 1'b0, ctrl_wr = 1'b0, pat_valid = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00, pat_data = 8'h00;
    logic       pat_ready, pix_fg, cell_start;

    int errors = 0, checks = 0;
    bit done = 1'b0;
    int m_pend, m_w, m_a, m_idx, m_byte, m_have;
    bit e_fg, e_cs;

    always #2.5 clk = ~clk;

    char_cell_serializer i_char_cell_serializer (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_en(line_en),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .pat_valid(pat_valid),
        .pat_data(pat_data), .pat_ready(pat_ready), .pix_fg(pix_fg),
        .cell_start(cell_start));

    task automatic chk(input string tag, input string sig, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, sig, act, exp, $time);
        end
    endtask

    // Behavioural model: advances one clock using the inputs now applied.
    task automatic model_step();
        int a;
        e_cs = pix_en && line_en && (m_idx == 0);
        if (!line_en) begin
            e_fg = 1'b0; m_idx = 0; m_have = 0;
        end else if (pix_en) begin
            if (m_idx == 0) begin
                m_w = (m_pend >> 4) & 15;
                m_a = m_pend & 15;
                m_have = pat_valid;
                m_byte = pat_data;
            end
            a = (m_a > 8) ? 8 : m_a;
            e_fg = (m_have != 0) && (m_idx < a) && (((m_byte >> (7 - m_idx)) & 1) == 1);
            m_idx = (m_idx + 1) % (m_w + 1);
        end
        if (ctrl_wr) m_pend = ctrl_wdata;
    endtask

    task automatic cycle(input string tag, input bit pe, input bit le, input bit v,
                         input bit wr, input logic [7:0] wd);
        @(negedge clk);
        chk(tag, "pix_fg", pix_fg, e_fg);
        chk(tag, "cell_start", cell_start, e_cs);
        pix_en = pe; line_en = le; pat_valid = v; ctrl_wr = wr; ctrl_wdata = wd;
        pat_data = 8'($urandom);
        #0.5;
        chk(tag, "pat_ready", pat_ready, pe && le && (m_idx == 0));
        model_step();
    endtask

    task automatic phase(input string tag, input logic [7:0] cfg, input int n,
                         input int pe_pct, input int v_pct, input int le_pct, input int wr_pct);
        cycle(tag, 1'b0, 1'b1, 1'b0, 1'b1, cfg);
        for (int i = 0; i < n; i++) begin
            bit wr;
            wr = (($urandom % 100) < wr_pct);
            cycle(tag, (($urandom % 100) < pe_pct), (($urandom % 100) < le_pct),
                  (($urandom % 100) < v_pct), wr, 8'($urandom));
        end
    endtask

    initial begin
        m_pend = 8'h78; m_w = 7; m_a = 8; m_idx = 0; m_byte = 0; m_have = 0;
        e_fg = 1'b0; e_cs = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        chk("R1", "pix_fg", pix_fg, 1'b0);
        chk("R1", "cell_start", cell_start, 1'b0);
        chk("R1", "pat_ready", pat_ready, 1'b0);
        rst_n = 1'b1;
        // R1 default 8-pixel cells with all bits active
        for (int i = 0; i < 200; i++) cycle("R1", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        phase("R3",  8'h78, 200, 100, 100, 100, 0);
        phase("R11", 8'h78, 300,  40, 100, 100, 0);
        phase("R4",  8'h53, 300, 100, 100, 100, 0);
        phase("R5",  8'h39, 300,  80, 100, 100, 0);
        phase("R5",  8'h28, 300, 100, 100, 100, 0);
        phase("R6",  8'hBC, 300, 100, 100, 100, 0);
        phase("R6",  8'hFF, 300,  90, 100, 100, 0);
        phase("R7",  8'h70, 300, 100, 100, 100, 0);
        phase("R2",  8'h00, 200, 100, 100, 100, 0);
        phase("R2",  8'h01, 200,  70, 100, 100, 0);
        phase("R8",  8'h78, 400,  80,  60, 100, 0);
        phase("R10", 8'h56, 400,  80,  90,  85, 0);
        phase("R9",  8'h78, 3000, 70,  85,  95, 10);
        cycle("R9", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule